// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block watches the write cycles a host issues to a byte-wide flash array and carries out whole-array and per-sector erase. A six-write command sequence selects the operation. A sector erase then opens an acceptance window during which the host may name further sectors. When the window lapses, an internal engine runs. It first clears every affected byte to zero. It then erases each chosen sector back to 0xFF, lowest sector index first. Finally it returns to normal array reads.

The array is a small register file. Its sector count and the number of bytes per sector are parameters. The window length and the erase time per sector are parameters counted in pulses of the `us_tick` input. While the block is busy, a read returns a status byte instead of array data. In that byte, bit 6 inverts on every read and bit 3 reports that the acceptance window has closed.

States: `ST_READ` (array reads, the decoder is live), `ST_WINDOW` (gathering sectors), `ST_PREPROG` (zero fill, one byte per clock), `ST_ERASE` (timed sector erase). The transitions are:
- READ→PREPROG on a chip erase command.
- READ→WINDOW on a sector erase command.
- WINDOW→READ on an abort.
- WINDOW→PREPROG when the window expires.
- PREPROG→ERASE after the last byte.
- ERASE→READ after the last sector.

Top module: `flash_erase_fsm`

## Requirements
- R1: After reset, `mode` is 0 (read) and `window_closed` is 0. A read of a location at sector s and word w returns 0x20 + s*WPS + w. The sector is taken from the top log2(NSEC) address bits and the word from the low log2(WPS) bits.
- R2: The writes (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x10) start a chip erase. `mode` becomes 2 in the cycle after the last write, and every sector ends at 0xFF.
- R3: The same five leading writes followed by data 0x30 at any address start a sector erase of the sector in that address's top bits. `mode` becomes 1 and `window_closed` stays 0.
- R4: In mode 1, each further 0x30 write adds its sector, in any order and with repeats allowed, and restarts the window. The window closes, and `mode` becomes 2, on the WIN_TICKS-th tick after the last accepted write.
- R5: In mode 1, a 0xB0 write is ignored: the window stays open and is not restarted. Any other write returns `mode` to 0 and leaves the array unchanged.
- R6: Mode 2 lasts exactly (number of selected sectors)*WPS clock cycles and is always followed by mode 3.
- R7: Mode 3 lasts exactly (selected sectors)*ERASE_TICKS ticks and then returns to mode 0. Selected sectors read 0xFF and all other sectors keep their data.
- R8: In modes 2 and 3 every write is ignored, including 0xB0 and complete command sequences. The durations and the final array are unchanged.
- R9: When `mode` is not 0, a read returns a status byte. Bit 3 equals `window_closed`, which is 1 exactly in modes 2 and 3. Bit 6 inverts between consecutive status reads. All other bits are 0.
- R10: A write that breaks the six-write sequence returns the decoder to its first step without changing `mode` or the array. A full sequence issued afterwards works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data, registered one cycle after `rd_en` |
| us_tick | input | 1 | Microsecond timing pulse |
| mode | output | 2 | 0 read, 1 window, 2 zero fill, 3 erase |
| window_closed | output | 1 | Sector window has expired and erase is under way |

## Verification
The hardest case to reach is a window that has been retriggered and gathered an arbitrary set of sectors, then expires on exactly the right tick. The bench drives every tick itself. It issues the sectors of a random subset in a random rotated order, with random tick gaps shorter than the window, sometimes repeating a sector. It then counts zero-fill cycles and erase ticks against the number of sectors. Aborts, ignored 0xB0 writes and writes injected while busy are added as directed cases.

// File: rtl/fe_pkg.sv
package fe_pkg;
    typedef enum logic [1:0] {
        ST_READ    = 2'd0,
        ST_WINDOW  = 2'd1,
        ST_PREPROG = 2'd2,
        ST_ERASE   = 2'd3
    } fe_state_t;

    localparam logic [7:0]  CD_UNLOCK_A = 8'hAA;
    localparam logic [7:0]  CD_UNLOCK_B = 8'h55;
    localparam logic [7:0]  CD_SETUP    = 8'h80;
    localparam logic [7:0]  CD_CHIP     = 8'h10;
    localparam logic [7:0]  CD_SECTOR   = 8'h30;
    localparam logic [7:0]  CD_SUSPEND  = 8'hB0;
    localparam logic [10:0] AD_UNLOCK_A = 11'h555;
    localparam logic [10:0] AD_UNLOCK_B = 11'h2AA;
endpackage

// File: rtl/fe_seq_decoder.sv
module fe_seq_decoder #(
    parameter int AW = 11,
    parameter int SB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          chip_go,
    output logic          sector_go,
    output logic [SB-1:0] sector_id
);
    import fe_pkg::*;

    logic [2:0]  step;
    logic [10:0] exp_addr;
    logic [7:0]  exp_data;
    logic        step_ok;

    always_comb begin
        unique case (step)
            3'd0, 3'd3: begin exp_addr = AD_UNLOCK_A; exp_data = CD_UNLOCK_A; end
            3'd1, 3'd4: begin exp_addr = AD_UNLOCK_B; exp_data = CD_UNLOCK_B; end
            3'd2:       begin exp_addr = AD_UNLOCK_A; exp_data = CD_SETUP;    end
            default:    begin exp_addr = AD_UNLOCK_A; exp_data = CD_CHIP;     end
        endcase
        step_ok = (wr_addr[10:0] == exp_addr) && (wr_data == exp_data);
    end

    assign chip_go   = wr_en && !clear && (step == 3'd5)
                       && (wr_addr[10:0] == AD_UNLOCK_A) && (wr_data == CD_CHIP);
    assign sector_go = wr_en && !clear && (step == 3'd5) && (wr_data == CD_SECTOR);
    assign sector_id = wr_addr[AW-1:AW-SB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            step <= 3'd0;
        else if (clear)
            step <= 3'd0;
        else if (wr_en) begin
            if (step == 3'd5 || !step_ok)
                step <= 3'd0;
            else
                step <= step + 3'd1;
        end
    end
endmodule

// File: rtl/fe_window_timer.sv
module fe_window_timer #(
    parameter int WIN_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(WIN_TICKS + 1);

    logic [CW-1:0] cnt;

    assign expire = run && !restart && tick && (cnt == CW'(WIN_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !run)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fe_array.sv
module fe_array #(
    parameter int NSEC = 4,
    parameter int WPS  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            zero_we,
    input  logic [$clog2(NSEC*WPS)-1:0]     zero_idx,
    input  logic                            ff_we,
    input  logic [$clog2(NSEC)-1:0]         ff_sec,
    input  logic [$clog2(NSEC*WPS)-1:0]     rd_idx,
    output logic [7:0]                      rd_byte
);
    localparam int NLOC = NSEC * WPS;
    localparam int IW   = $clog2(NLOC);
    localparam int SB   = $clog2(NSEC);

    logic [7:0] mem [NLOC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLOC; i++)
                mem[i] <= 8'(8'h20 + i);
        end else begin
            for (int i = 0; i < NLOC; i++) begin
                if (zero_we && zero_idx == IW'(i))
                    mem[i] <= 8'h00;
                else if (ff_we && ff_sec == SB'(i / WPS))
                    mem[i] <= 8'hFF;
            end
        end
    end

    assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/flash_erase_fsm.sv
module flash_erase_fsm #(
    parameter int AW          = 11,
    parameter int NSEC        = 4,
    parameter int WPS         = 4,
    parameter int WIN_TICKS   = 50,
    parameter int ERASE_TICKS = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          us_tick,
    output logic [1:0]    mode,
    output logic          window_closed
);
    import fe_pkg::*;

    localparam int SB  = $clog2(NSEC);
    localparam int WB  = $clog2(WPS);
    localparam int IW  = SB + WB;
    localparam int ECW = $clog2(ERASE_TICKS + 1);

    fe_state_t       state, state_nx;
    logic [NSEC-1:0] sel_mask, work_mask;
    logic [WB-1:0]   word_cnt;
    logic [ECW-1:0]  tick_cnt;
    logic            tgl;

    logic            chip_go, sector_go;
    logic [SB-1:0]   sector_id;
    logic            win_add, win_abort, win_expire;
    logic [SB-1:0]   cur_sec;
    logic            last_sec, word_last, erase_step;
    logic [7:0]      arr_byte;
    logic            unused_rd;

    function automatic logic [SB-1:0] lowest(input logic [NSEC-1:0] m);
        lowest = '0;
        for (int i = NSEC - 1; i >= 0; i--)
            if (m[i]) lowest = SB'(i);
    endfunction

    fe_seq_decoder #(.AW(AW), .SB(SB)) u_dec (
        .clk(clk), .rst_n(rst_n), .clear(state != ST_READ),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .chip_go(chip_go), .sector_go(sector_go), .sector_id(sector_id)
    );

    fe_window_timer #(.WIN_TICKS(WIN_TICKS)) u_win (
        .clk(clk), .rst_n(rst_n), .run(state == ST_WINDOW),
        .restart(sector_go || win_add), .tick(us_tick), .expire(win_expire)
    );

    fe_array #(.NSEC(NSEC), .WPS(WPS)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .zero_we(state == ST_PREPROG), .zero_idx({cur_sec, word_cnt}),
        .ff_we(erase_step && last_sec || erase_step && !last_sec),
        .ff_sec(cur_sec),
        .rd_idx(IW'({rd_addr[AW-1:AW-SB], rd_addr[WB-1:0]})),
        .rd_byte(arr_byte)
    );

    assign unused_rd  = ^rd_addr[AW-SB-1:WB];
    assign win_add    = (state == ST_WINDOW) && wr_en && (wr_data == CD_SECTOR);
    assign win_abort  = (state == ST_WINDOW) && wr_en && (wr_data != CD_SECTOR)
                        && (wr_data != CD_SUSPEND);
    assign cur_sec    = lowest(work_mask);
    assign last_sec   = (work_mask & ~(NSEC'(1) << cur_sec)) == '0;
    assign word_last  = (word_cnt == WB'(WPS - 1));
    assign erase_step = (state == ST_ERASE) && us_tick
                        && (tick_cnt == ECW'(ERASE_TICKS - 1));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READ: begin
                if (chip_go)        state_nx = ST_PREPROG;
                else if (sector_go) state_nx = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (win_abort)       state_nx = ST_READ;
                else if (win_expire) state_nx = ST_PREPROG;
            end
            ST_PREPROG: begin
                if (word_last && last_sec) state_nx = ST_ERASE;
            end
            ST_ERASE: begin
                if (erase_step && last_sec) state_nx = ST_READ;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READ;
        else        state <= state_nx;
    end

    // sector buffer and walk counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_mask  <= '0;
            work_mask <= '0;
            word_cnt  <= '0;
            tick_cnt  <= '0;
        end else begin
            unique case (state)
                ST_READ: begin
                    word_cnt <= '0;
                    tick_cnt <= '0;
                    if (chip_go) begin
                        sel_mask  <= '1;
                        work_mask <= '1;
                    end else if (sector_go) begin
                        sel_mask <= NSEC'(1) << sector_id;
                    end else begin
                        sel_mask  <= '0;
                        work_mask <= '0;
                    end
                end
                ST_WINDOW: begin
                    if (win_abort)
                        sel_mask <= '0;
                    else if (win_add)
                        sel_mask <= sel_mask | (NSEC'(1) << wr_addr[AW-1:AW-SB]);
                    else if (win_expire)
                        work_mask <= sel_mask;
                end
                ST_PREPROG: begin
                    word_cnt <= word_cnt + 1'b1;
                    if (word_last) begin
                        word_cnt <= '0;
                        if (last_sec) work_mask <= sel_mask;
                        else          work_mask <= work_mask & ~(NSEC'(1) << cur_sec);
                    end
                end
                ST_ERASE: begin
                    if (us_tick) begin
                        if (tick_cnt == ECW'(ERASE_TICKS - 1)) begin
                            tick_cnt  <= '0;
                            work_mask <= work_mask & ~(NSEC'(1) << cur_sec);
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mode          = state;
        window_closed = (state == ST_PREPROG) || (state == ST_ERASE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            tgl     <= 1'b0;
        end else if (rd_en) begin
            if (state == ST_READ) begin
                rd_data <= arr_byte;
            end else begin
                rd_data <= {1'b0, tgl, 2'b00, window_closed, 3'b000};
                tgl     <= ~tgl;
            end
        end
    end
endmodule

// File: rtl/fe_checker.sv
module fe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       window_closed,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       us_tick
);
    AST_OPEN_NEEDS_SECTOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd0 && mode == 2'd1) |-> ($past(wr_en) && $past(wr_data) == 8'h30)); // R3
    AST_CLOSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd1 && mode == 2'd2) |-> $past(us_tick)); // R4
    AST_ABORT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd1 && mode == 2'd0) |-> $past(wr_en)); // R5
    AST_PREPROG_THEN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |=> (mode == 2'd2 || mode == 2'd3)); // R6
    AST_ERASE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd3 && mode != 2'd3) |-> (mode == 2'd0 && $past(us_tick))); // R7
    AST_BUSY_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && !us_tick) |=> (mode == 2'd3)); // R8
    AST_CLOSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_closed) |-> ($past(mode) != 2'd3)); // R9
endmodule

bind flash_erase_fsm fe_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .window_closed(window_closed),
    .wr_en(wr_en), .wr_data(wr_data), .us_tick(us_tick)
);

// File: tb/flash_erase_fsm_test.sv
module flash_erase_fsm_test;
    localparam int AW = 11, NSEC = 4, WPS = 4, WIN = 50, ET = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, us_tick = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic [1:0]    mode;
    logic          window_closed;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_mem [NSEC*WPS];

    flash_erase_fsm #(.AW(AW), .NSEC(NSEC), .WPS(WPS), .WIN_TICKS(WIN), .ERASE_TICKS(ET)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .us_tick(us_tick),
        .mode(mode), .window_closed(window_closed)
    );

    always #10ns clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk); us_tick = 1'b1;
        @(negedge clk); us_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tk();
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; v = rd_data;
    endtask

    function automatic logic [AW-1:0] loc(input int s, input int w);
        return AW'((s << (AW - 2)) | w);
    endfunction

    task automatic prefix();
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
    endtask

    task automatic check_array(input string req);
        logic [7:0] v;
        for (int s = 0; s < NSEC; s++)
            for (int w = 0; w < WPS; w++) begin
                rd(loc(s, w) | AW'(8'h0C), v);
                chk(req, v, exp_mem[s*WPS+w]);
            end
    endtask

    // entered with mode == 2 at a negedge
    task automatic run_erase(input logic [NSEC-1:0] m, input bit poke);
        int n, t, nsel;
        logic [7:0] s1, s2;
        nsel = $countones(m);
        n = 0;
        chk("R6 mode at zero fill", mode, 2);
        while (mode == 2'd2 && n < 1000) begin @(negedge clk); n++; end
        chk("R6 zero-fill cycles", n, nsel * WPS);
        chk("R6 erase follows", mode, 3);
        rd(0, s1); rd(0, s2);
        chk("R9 status closed bit", s1 & 8'hBF, 8'h08);
        chk("R9 toggle bit", (s1 ^ s2) & 8'h40, 8'h40);
        if (poke) begin
            wr(11'h555, 8'hB0); prefix(); wr(loc(3, 1), 8'h30); wr(11'h123, 8'h45);
            chk("R8 write ignored in erase", mode, 3);
        end
        t = 0;
        while (mode == 2'd3 && t < 1000) begin tk(); t++; end
        chk("R7 erase ticks", t, nsel * ET);
        chk("R7 back to read", mode, 0);
        chk("R9 closed flag cleared", window_closed, 0);
        for (int s = 0; s < NSEC; s++)
            if (m[s]) for (int w = 0; w < WPS; w++) exp_mem[s*WPS+w] = 8'hFF;
        check_array("R7 array after erase");
    endtask

    initial begin
        #(20ns * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int unsigned seed;
        seed = $urandom(32'h1F3A);
        for (int i = 0; i < NSEC*WPS; i++) exp_mem[i] = 8'(8'h20 + i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 window_closed", window_closed, 0);
        check_array("R1 initial data");

        // R10 broken sequences
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h90);
        wr(11'h555, 8'h80); wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h30);
        chk("R10 mode after mismatch", mode, 0);
        for (int k = 0; k < 20; k++) wr(AW'($urandom), 8'($urandom) & 8'h7F);
        chk("R10 mode after random writes", mode, 0);
        check_array("R10 array unchanged");

        // R5 abort in window
        prefix(); wr(loc(1, 0), 8'h30);
        chk("R3 window open", mode, 1);
        chk("R3 closed flag low", window_closed, 0);
        rd(0, v);
        chk("R9 status in window", v & 8'hBF, 8'h00);
        ticks(7); wr(11'h123, 8'h45);
        chk("R5 abort to read", mode, 0);
        check_array("R5 array unchanged after abort");

        // R5 suspend ignored, no restart; R4 exact close
        prefix(); wr(loc(2, 3), 8'h30);
        ticks(10); wr(11'h555, 8'hB0);
        chk("R5 suspend keeps window", mode, 1);
        ticks(WIN - 11);
        chk("R4 still open before last tick", mode, 1);
        tk();
        chk("R4 closed on final tick", mode, 2);
        run_erase(4'b0100, 1'b1);

        // R4 retrigger, random sets and orders
        for (int it = 0; it < 4; it++) begin
            logic [NSEC-1:0] m;
            int r, first;
            m = NSEC'($urandom_range(1, 15));
            r = $urandom_range(0, 3);
            first = 1;
            for (int k = 0; k < NSEC; k++) begin
                int s;
                s = (k * 3 + r) % NSEC;
                if (m[s]) begin
                    if (first) begin prefix(); wr(loc(s, 2), 8'h30); first = 0; end
                    else begin
                        ticks($urandom_range(0, WIN - 1));
                        wr(loc(s, 1), 8'h30);
                        if ($urandom_range(0, 1) == 1) begin
                            ticks($urandom_range(0, WIN - 1));
                            wr(loc(s, 0), 8'h30);
                        end
                    end
                end
            end
            ticks(WIN - 1);
            chk("R4 window open after retrigger", mode, 1);
            tk();
            chk("R4 window closes", mode, 2);
            run_erase(m, it[0]);
        end

        // R2 chip erase with writes during it
        prefix(); wr(11'h555, 8'h10);
        chk("R2 chip erase starts", mode, 2);
        chk("R2 closed flag", window_closed, 1);
        run_erase('1, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule